// File: doc/BRIEF.md
# Pseudo-SRAM Nonvolatile Memory Front End

This block is a clock-driven model of the device-side control of a byte-wide nonvolatile memory that offers an asynchronous pseudo-SRAM pin interface. A fast internal clock samples the pins: two chip enables (one active low, one active high), an active-low write strobe and an active-low output enable. The block captures the address when an access opens, decodes the operating mode, writes into or reads from an internal cell array, and either drives or floats the data pins. The bidirectional data bus is split into an input, an output and an output-enable, which the pad ring combines.

An access opens only on a falling edge of the active-low enable while the active-high enable is asserted. The address is captured at that edge and held until the access closes. Write data is committed on the closing edge of the write strobe, which is the write strobe rising or the active-low enable rising, whichever comes first. Each access must be followed by a precharge interval with the active-low enable high. An access that starts too early is refused and raises a sticky protocol-error flag.

The pin address is `ADDR_W` bits wide. The array holds 2^`CELL_AW` words. The address is folded onto the array: bit i of the address is XORed into cell-index bit (i mod `CELL_AW`). With the default widths the pins span the full 17-bit word space, and the storage stays small.

Top module: `psram_front`

## Requirements
- R1: While reset is active and on the first cycle after it, `dataOutEn` is 0 and `protoErr` is 0.
- R2: While `chipSelN` is high (1), `dataOutEn` is 0, whatever the levels of the other pins.
- R3: While `chipSelHi` is low (0), no access opens and no word is written. `dataOutEn` is 0 throughout.
- R4: The address is captured on the synchronized falling edge of `chipSelN`. A change on `addrIn` after that edge does not change which word is read or written.
- R5: With an access open, `writeN` high and `outEnN` low, `dataOutEn` is 1 and `dataOut` carries the word at the captured address. The path from a pin change to the outputs is a two-flop synchronizer followed by one output register.
- R6: A write commits the `dataIn` value present at the closing edge of the write strobe. The closing edge is the synchronized rise of `writeN`, or the rise of `chipSelN` while `writeN` is still low, whichever comes first. Each strobe commits exactly once.
- R7: With an access open and both `writeN` and `outEnN` high, `dataOutEn` stays 0.
- R8: PC_CYC is ceil(`PRECHARGE_PS` / `CLK_PERIOD_PS`), which is 8 by default. A new access is accepted when `chipSelN` has been high for at least PC_CYC+1 clock cycles. An access after exactly 9 high cycles is accepted.
- R9: A falling edge of `chipSelN` that comes after PC_CYC or fewer high cycles is ignored: nothing is read and nothing is written. It sets `protoErr`, which stays 1 until reset.
- R10: Bit i of the captured address is XORed into cell-index bit (i mod `CELL_AW`). Two addresses with the same folded index reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipSelN | input | 1 | Chip enable, active low; its falling edge opens an access |
| chipSelHi | input | 1 | Chip enable, active high |
| writeN | input | 1 | Write strobe, active low |
| outEnN | input | 1 | Output enable, active low |
| addrIn | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Data bus, inbound half |
| dataOut | output | DATA_W | Data bus, outbound half |
| dataOutEn | output | 1 | Drive enable for the data bus; 0 means high impedance |
| protoErr | output | 1 | Sticky flag for an access started inside the precharge interval |

## Verification
The assertions assume the four control pins are the only asynchronous inputs that matter for timing. They also assume that `addrIn` is stable around the enable's falling edge and that `dataIn` is stable around the write strobe's closing edge, for at least the synchronizer latency. The stimulus changes every pin only on the falling clock edge. It holds the address for three cycles after the enable falls and holds the write data for several cycles past the strobe's release, so these conditions are always met. The precharge intervals are chosen on both sides of the PC_CYC+1 boundary, so the assertions on the accept and refuse paths both see traffic.

// File: rtl/psram_front_pkg.sv
package psram_front_pkg;

  // strobes from the control FSM to the datapath, valid for one cycle
  typedef struct packed {
    logic latchAddr;   // capture address at access start
    logic doWrite;     // commit dataIn into the captured word
    logic driveOut;    // read mode active this cycle
  } ctlStrobe_t;

  // bit order of the synchronized control vector
  localparam int unsigned PIN_CE1N = 3;
  localparam int unsigned PIN_CE2  = 2;
  localparam int unsigned PIN_WEN  = 1;
  localparam int unsigned PIN_OEN  = 0;
  localparam int unsigned PIN_CNT  = 4;

endpackage

// File: rtl/psram_front_sync.sv
module psram_front_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stageOne;
  logic [W-1:0] stageTwo;

  // two flops per pin, each bit reset to its idle level
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageOne[b] <= RST_VAL[b];
        stageTwo[b] <= RST_VAL[b];
      end else begin
        stageOne[b] <= asyncIn[b];
        stageTwo[b] <= stageOne[b];
      end
    end
  end

  assign syncOut = stageTwo;

endmodule

// File: rtl/psram_front_ctrl.sv
module psram_front_ctrl
  import psram_front_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned PRECHARGE_PS  = 40000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ce1S,
  input  logic       ce2S,
  input  logic       weS,
  input  logic       oeS,
  output ctlStrobe_t str,
  output logic       protoErr
);

  localparam int unsigned PC_CYC = (PRECHARGE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int unsigned PCW    = $clog2(PC_CYC + 1);

  logic           ce1Prev;
  logic           wePrev;
  logic           accOpen;
  logic [PCW-1:0] pcCnt;
  logic           ce1Fall;
  logic           ce1Rise;
  logic           startReq;
  logic           startOk;
  logic           pcBusy;

  always_comb begin
    ce1Fall  = ce1Prev & ~ce1S;
    ce1Rise  = ~ce1Prev & ce1S;
    pcBusy   = (pcCnt != '0);
    startReq = ce1Fall & ce2S;
    startOk  = startReq & ~pcBusy;

    str.latchAddr = startOk;
    // closing edge of the write strobe: WE rises, or CE1 rises with WE still low
    str.doWrite   = accOpen & ce2S & ~wePrev & (weS | ce1S);
    str.driveOut  = accOpen & ~ce1S & ce2S & weS & ~oeS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ce1Prev  <= 1'b1;
      wePrev   <= 1'b1;
      accOpen  <= 1'b0;
      pcCnt    <= '0;
      protoErr <= 1'b0;
    end else begin
      ce1Prev <= ce1S;
      wePrev  <= weS;

      if (startOk)            accOpen <= 1'b1;
      else if (ce1S || !ce2S) accOpen <= 1'b0;

      if (ce1Rise)     pcCnt <= PCW'(PC_CYC);
      else if (pcBusy) pcCnt <= pcCnt - PCW'(1);

      if (startReq && pcBusy) protoErr <= 1'b1;
    end
  end

  // R9: the error flag never clears outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R8: an access only opens once the precharge count has run out
  a_r8_open_after_precharge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accOpen) |-> (pcCnt == '0));

  // R3: an access opens only with CE1 low and CE2 high
  a_r3_open_needs_enables: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accOpen) |-> $past(!ce1S && ce2S));

  // R6: one strobe, one commit
  a_r6_one_commit: assert property (@(posedge clk) disable iff (!rstN)
    str.doWrite |=> !str.doWrite);

  // R2: deselection ends read mode by the next cycle
  a_r2_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    ce1S |=> !str.driveOut);

endmodule

// File: rtl/psram_front_dp.sv
module psram_front_dp
  import psram_front_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CELL_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        str,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  localparam int unsigned CELLS = 1 << CELL_AW;

  logic [DATA_W-1:0]  cells [CELLS];
  logic [CELL_AW-1:0] foldIdx;
  logic [CELL_AW-1:0] addrLat;

  // fold the full pin address onto the cell index
  always_comb begin
    foldIdx = '0;
    for (int i = 0; i < int'(ADDR_W); i++) begin
      foldIdx[i % int'(CELL_AW)] = foldIdx[i % int'(CELL_AW)] ^ addrIn[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat   <= '0;
      dataOut   <= '0;
      dataOutEn <= 1'b0;
    end else begin
      if (str.latchAddr) addrLat <= foldIdx;
      dataOut   <= cells[addrLat];
      dataOutEn <= str.driveOut;
    end
  end

  always_ff @(posedge clk) begin
    if (str.doWrite) cells[addrLat] <= dataIn;
  end

  // R4: the captured address only moves at an access start
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    !str.latchAddr |=> $stable(addrLat));

  // R5: read mode never coexists with a new address capture
  a_r5_no_read_at_capture: assert property (@(posedge clk) disable iff (!rstN)
    str.latchAddr |-> !str.driveOut);

endmodule

// File: rtl/psram_front.sv
module psram_front
  import psram_front_pkg::*;
#(
  parameter int unsigned ADDR_W        = 17,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CELL_AW       = 10,
  parameter int unsigned CLK_PERIOD_PS = 5000,
  parameter int unsigned PRECHARGE_PS  = 40000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic              chipSelHi,
  input  logic              writeN,
  input  logic              outEnN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              protoErr
);

  localparam logic [PIN_CNT-1:0] PIN_IDLE = 4'b1011;

  logic [PIN_CNT-1:0] pinRaw;
  logic [PIN_CNT-1:0] pinSync;
  ctlStrobe_t         str;

  always_comb begin
    pinRaw           = '0;
    pinRaw[PIN_CE1N] = chipSelN;
    pinRaw[PIN_CE2]  = chipSelHi;
    pinRaw[PIN_WEN]  = writeN;
    pinRaw[PIN_OEN]  = outEnN;
  end

  psram_front_sync #(
    .W       (PIN_CNT),
    .RST_VAL (PIN_IDLE)
  ) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinRaw),
    .syncOut (pinSync)
  );

  psram_front_ctrl #(
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .PRECHARGE_PS  (PRECHARGE_PS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ce1S     (pinSync[PIN_CE1N]),
    .ce2S     (pinSync[PIN_CE2]),
    .weS      (pinSync[PIN_WEN]),
    .oeS      (pinSync[PIN_OEN]),
    .str      (str),
    .protoErr (protoErr)
  );

  psram_front_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CELL_AW (CELL_AW)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .str       (str),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .dataOutEn (dataOutEn)
  );

endmodule

// File: tb/test_psram_front.sv
module test_psram_front;

  localparam int CLK_P   = 10;
  localparam int ADDR_W  = 17;
  localparam int DATA_W  = 8;
  localparam int CELL_AW = 10;
  localparam int PC_CYC  = 8;   // ceil(40000 / 5000)

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              chipSelN = 1'b1;
  logic              chipSelHi = 1'b1;
  logic              writeN = 1'b1;
  logic              outEnN = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic [DATA_W-1:0] dataIn = '0;
  logic [DATA_W-1:0] dataOut;
  logic              dataOutEn;
  logic              protoErr;

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  psram_front i_psram_front (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .chipSelHi(chipSelHi),
    .writeN(writeN), .outEnN(outEnN), .addrIn(addrIn), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .protoErr(protoErr)
  );

  // ---------------- behavioural reference ----------------
  logic [3:0]        hist[$];           // {ce1n, ce2, wen, oen} sampled per edge
  logic [DATA_W-1:0] mMem [int];
  int                mAddr;
  bit                mOpen, mEn, mErr;
  logic [DATA_W-1:0] mOut;
  int                edgeNo, riseEdge;

  function automatic int foldAddr(logic [ADDR_W-1:0] a);
    int idx = 0;
    for (int i = 0; i < ADDR_W; i++)
      if (a[i]) idx = idx ^ (1 << (i % CELL_AW));
    return idx;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {};
      repeat (4) hist.push_front(4'b1011);
      mOpen = 0; mEn = 0; mErr = 0; mAddr = 0; mOut = '0;
      edgeNo = 0; riseEdge = -1000;
    end else begin
      logic [3:0] c, p;
      bit start, early, wr, drv;
      edgeNo++;
      hist.push_front({chipSelN, chipSelHi, writeN, outEnN});
      void'(hist.pop_back());
      c = hist[2];
      p = hist[3];
      start = p[3] && !c[3] && c[2];
      early = (edgeNo - riseEdge) <= PC_CYC;
      wr    = mOpen && c[2] && !p[1] && (c[1] || c[3]);
      drv   = mOpen && !c[3] && c[2] && c[1] && !c[0];
      mOut  = mMem.exists(mAddr) ? mMem[mAddr] : '0;
      if (wr) mMem[mAddr] = dataIn;
      if (start && !early) mAddr = foldAddr(addrIn);
      if (start && early) mErr = 1;
      mEn = drv;
      if (start && !early) mOpen = 1;
      else if (c[3] || !c[2]) mOpen = 0;
      if (!p[3] && c[3]) riseEdge = edgeNo;
    end
  end

  // cycle-by-cycle comparison, sampled a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rstN && !done) begin
      checks++;
      if (dataOutEn !== mEn || protoErr !== mErr || (mEn && dataOut !== mOut)) begin
        errors++;
        $display("FAIL %s cycle %0d: en=%0b err=%0b out=%02h expected en=%0b err=%0b out=%02h",
                 curReq, edgeNo, dataOutEn, protoErr, dataOut, mEn, mErr, mOut);
      end
    end
  end

  // ---------------- directed checks and stimulus ----------------
  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idleGap(int gap);
    repeat (gap) @(negedge clk);
  endtask

  task automatic writeWord(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, bit closeByCe, int gap);
    @(negedge clk); addrIn = a; chipSelN = 1'b0; writeN = 1'b1; outEnN = 1'b1;
    repeat (4) @(negedge clk);
    writeN = 1'b0; dataIn = d;
    repeat (4) @(negedge clk);
    if (closeByCe) begin
      chipSelN = 1'b1;
      repeat (4) @(negedge clk);
      writeN = 1'b1;
      idleGap(gap - 4);
    end else begin
      writeN = 1'b1;
      repeat (4) @(negedge clk);
      chipSelN = 1'b1;
      idleGap(gap);
    end
  endtask

  task automatic readWord(logic [ADDR_W-1:0] a, int gap, output logic [DATA_W-1:0] got,
                          output logic en);
    @(negedge clk); addrIn = a; chipSelN = 1'b0; writeN = 1'b1; outEnN = 1'b1;
    repeat (3) @(negedge clk);
    addrIn = ~a;                       // R4: address moves after capture
    outEnN = 1'b0;
    repeat (6) @(posedge clk);
    #(CLK_P/4);
    got = dataOut; en = dataOutEn;
    @(negedge clk); outEnN = 1'b1; chipSelN = 1'b1;
    idleGap(gap);
  endtask

  initial begin
    logic [DATA_W-1:0] got;
    logic en;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #(CLK_P/4);
    curReq = "R1";
    checkVal("R1 outEn after reset", dataOutEn, 0);
    checkVal("R1 protoErr after reset", protoErr, 0);
    idleGap(12);

    curReq = "R6";
    writeWord(17'h00010, 8'hA5, 1'b0, 12);
    writeWord(17'h10123, 8'h3C, 1'b0, 12);
    writeWord(17'h00222, 8'h5A, 1'b1, 12);   // closed by CE1 rise

    curReq = "R5";
    readWord(17'h00010, 12, got, en);
    checkVal("R5 read enable", en, 1);
    checkVal("R5 R4 read data 0x00010", got, 8'hA5);
    readWord(17'h10123, 12, got, en);
    checkVal("R5 read data 0x10123", got, 8'h3C);
    readWord(17'h00222, 12, got, en);
    checkVal("R6 CE1-closed write data", got, 8'h5A);

    curReq = "R10";
    readWord(17'h00411, 12, got, en);        // folds onto index 0x010
    checkVal("R10 aliased read", got, 8'hA5);

    curReq = "R7";
    @(negedge clk); addrIn = 17'h00010; chipSelN = 1'b0;
    repeat (8) begin
      @(posedge clk); #(CLK_P/4);
      checkVal("R7 output disable", dataOutEn, 0);
    end
    @(negedge clk); chipSelN = 1'b1; idleGap(12);

    curReq = "R2";
    @(negedge clk); outEnN = 1'b0;
    repeat (8) begin
      @(posedge clk); #(CLK_P/4);
      checkVal("R2 CE1 high floats bus", dataOutEn, 0);
    end
    @(negedge clk); outEnN = 1'b1; idleGap(12);

    curReq = "R3";
    @(negedge clk); chipSelHi = 1'b0;
    @(negedge clk); chipSelN = 1'b0; outEnN = 1'b0;
    repeat (8) begin
      @(posedge clk); #(CLK_P/4);
      checkVal("R3 CE2 low floats bus", dataOutEn, 0);
    end
    @(negedge clk); outEnN = 1'b1; writeN = 1'b0; dataIn = 8'hFF;
    repeat (4) @(negedge clk);
    writeN = 1'b1;
    repeat (4) @(negedge clk);
    chipSelN = 1'b1;
    idleGap(6);
    chipSelHi = 1'b1;
    idleGap(12);
    readWord(17'h00010, 12, got, en);
    checkVal("R3 no write while CE2 low", got, 8'hA5);

    curReq = "R8";
    readWord(17'h10123, PC_CYC, got, en);   // CE1 high exactly PC_CYC+1 cycles
    readWord(17'h00222, 12, got, en);
    checkVal("R8 boundary access accepted", got, 8'h5A);
    checkVal("R8 no error at boundary", protoErr, 0);

    curReq = "R9";
    writeWord(17'h00010, 8'hA5, 1'b0, PC_CYC - 1); // CE1 high only PC_CYC cycles
    writeWord(17'h00010, 8'h00, 1'b0, 12);         // refused
    checkVal("R9 early start flagged", protoErr, 1);
    readWord(17'h00010, 12, got, en);
    checkVal("R9 refused write left data", got, 8'hA5);
    idleGap(20);
    checkVal("R9 flag sticky", protoErr, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule